// File: doc/BRIEF.md
# ATA Task-File Host Register Interface

This block sits between a host register bus and the device side of an ATA-style disk controller. The host sees nine word addresses: the data port, the feature/error pair, the sector count, three address bytes, the device/head register, the command/status pair and the device-control/alternate-status pair. Writes to the parameter registers are stored in the block and driven out to the command engine. Command bytes, device-control bytes and data-port transfers go out as one-cycle strobes. The block does not execute commands and does not move data.

Parameter and command writes are accepted only while the device reports that it is neither busy nor requesting data. The block also keeps the level interrupt toward the host. A device-side pulse sets it. Reading the primary status clears it, and so does an accepted command write. Reading the alternate status leaves it alone.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After reset the stored parameter registers, `host_rdata`, `irq` and every strobe output are zero.
- R2: A write to address 1 (feature), 2 (count), 3, 4, 5 (address bytes low to high) or 6 (device) stores `host_wdata[7:0]` into that register. The new value appears on the matching `tf_*` output on the cycle after the write.
- R3: The registers count as writable only when `dev_status` bit 7 (busy) and bit 3 (data request) are both 0. A write to addresses 1 to 6 at any other time leaves every stored register unchanged.
- R4: A write to address 7 while the registers are writable pulses `cmd_valid` for one cycle, on the cycle after the write, with `cmd_byte` = `host_wdata[7:0]`. It also clears `irq` on that same cycle. A write to address 7 while they are not writable produces no pulse and leaves `irq` unchanged.
- R5: A read of address 7 returns `dev_status` zero-extended on `host_rdata` on the cycle after the read, and clears `irq` on that same cycle.
- R6: A read of address 8 returns `dev_status` zero-extended on the cycle after the read and leaves `irq` unchanged.
- R7: A write to address 8 pulses `ctrl_valid` for one cycle, on the cycle after the write, with `ctrl_byte` = `host_wdata[7:0]`. Writability does not affect this.
- R8: A read of address 1 returns `dev_error` zero-extended, not the stored feature value.
- R9: A write to address 0 pulses `pio_wr` on the following cycle with `pio_wdata` = `host_wdata`. A read of address 0 returns `data_rdata` on `host_rdata` and pulses `pio_rd` on the following cycle. At most one strobe is active in any cycle.
- R10: `dev_irq_pulse` sets `irq` on the next cycle, and `irq` stays set until a clearing access. If a set and a clear arrive in the same cycle, the set wins.
- R11: A read of addresses 9 to 15 returns zero. A write to them changes no output and no stored register.
- R12: A read of address 2 to 6 returns the stored byte zero-extended. When no read is issued, `host_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Register word address |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, never together with host_wr |
| host_wdata | input | PIO_W | Write data |
| host_rdata | output | PIO_W | Registered read data, valid one cycle after host_rd |
| dev_status | input | 8 | Current device status byte |
| dev_error | input | 8 | Current device error byte |
| dev_irq_pulse | input | 1 | Device interrupt event |
| data_rdata | input | PIO_W | Word offered by the data engine |
| irq | output | 1 | Level interrupt to host |
| tf_feature | output | 8 | Stored feature byte |
| tf_count | output | 8 | Stored sector count |
| tf_lba | output | 24 | Stored address bytes, high byte first |
| tf_device | output | 8 | Stored device/head byte |
| cmd_valid | output | 1 | Command issue strobe |
| cmd_byte | output | 8 | Command opcode |
| ctrl_valid | output | 1 | Device-control write strobe |
| ctrl_byte | output | 8 | Device-control value |
| pio_wr | output | 1 | Data-port write strobe |
| pio_rd | output | 1 | Data-port read strobe |
| pio_wdata | output | PIO_W | Data-port write word |

## Verification
Every access takes effect on the rising edge that samples it. Read data, strobes, `irq` and the stored registers therefore all change exactly one cycle later, and none of them needs a wait state. The bench applies one access per cycle at the falling edge. It compares every output at the next falling edge, after the one register stage, against a bench model that has just been advanced by that access. The directed cases hit the edges that matter: busy and data-request each blocking a write alone, a set and a clear landing in the same cycle, and the alternate-status read.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
    localparam int TF_W    = 8;
    localparam int PIO_W   = 16;
    localparam int ADDR_W  = 4;
    localparam int NUM_TF  = 6;          // feature, count, lba0..2, device
    localparam int NUM_MAP = 9;          // mapped word addresses 0..8

    localparam int ADR_DATA = 0;
    localparam int ADR_FEAT = 1;
    localparam int ADR_CNT  = 2;
    localparam int ADR_DEV  = 6;
    localparam int ADR_CMD  = 7;
    localparam int ADR_ALT  = 8;

    localparam int BSY_BIT = 7;
    localparam int DRQ_BIT = 3;

    typedef struct packed {
        logic [NUM_TF-1:0][TF_W-1:0] tf;
        logic [PIO_W-1:0]            rdata;
        logic                        cmd_v;
        logic [TF_W-1:0]             cmd_b;
        logic                        ctl_v;
        logic [TF_W-1:0]             ctl_b;
        logic                        pio_rd;
        logic                        pio_wr;
        logic [PIO_W-1:0]            pio_wd;
    } tf_state_t;
endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
    import ata_tf_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int NMAP = NUM_MAP
) (
    input  logic [AW-1:0]   addr,
    input  logic            wr,
    input  logic            rd,
    output logic [NMAP-1:0] wr_sel,
    output logic [NMAP-1:0] rd_sel
);
    for (genvar i = 0; i < NMAP; i++) begin : g_sel
        assign wr_sel[i] = wr && (addr == AW'(i));
        assign rd_sel[i] = rd && !wr && (addr == AW'(i));
    end

    always_comb begin
        assert ($onehot0(wr_sel) && $onehot0(rd_sel))
            else $error("assert_decode_onehot_R11");
    end
endmodule

// File: rtl/ata_tf_irq.sv
module ata_tf_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (clr_evt) irq_d = 1'b0;
        if (set_evt) irq_d = 1'b1;      // a new event is never lost
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> irq_q);
    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !clr_evt) |=> irq_q);
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
    import ata_tf_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = PIO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic [7:0]    dev_status,
    input  logic [7:0]    dev_error,
    input  logic          dev_irq_pulse,
    input  logic [DW-1:0] data_rdata,
    output logic          irq,
    output logic [7:0]    tf_feature,
    output logic [7:0]    tf_count,
    output logic [23:0]   tf_lba,
    output logic [7:0]    tf_device,
    output logic          cmd_valid,
    output logic [7:0]    cmd_byte,
    output logic          ctrl_valid,
    output logic [7:0]    ctrl_byte,
    output logic          pio_wr,
    output logic          pio_rd,
    output logic [DW-1:0] pio_wdata
);
    localparam int TB = TF_W;

    logic [NUM_MAP-1:0] wr_sel, rd_sel;
    logic               writable;
    logic               irq_clr;
    tf_state_t          st_d, st_q;

    ata_tf_decode #(.AW(AW), .NMAP(NUM_MAP)) u_decode (
        .addr  (host_addr),
        .wr    (host_wr),
        .rd    (host_rd),
        .wr_sel(wr_sel),
        .rd_sel(rd_sel)
    );

    assign writable = !dev_status[BSY_BIT] && !dev_status[DRQ_BIT];
    assign irq_clr  = rd_sel[ADR_CMD] || (wr_sel[ADR_CMD] && writable);

    ata_tf_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(dev_irq_pulse),
        .clr_evt(irq_clr),
        .irq    (irq)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rdata  = '0;
        st_d.cmd_v  = 1'b0;
        st_d.ctl_v  = 1'b0;
        st_d.pio_rd = 1'b0;
        st_d.pio_wr = 1'b0;

        // parameter registers live at addresses 1..6
        for (int i = 0; i < NUM_TF; i++) begin
            if (wr_sel[i+ADR_FEAT] && writable) st_d.tf[i] = host_wdata[TB-1:0];
        end

        if (wr_sel[ADR_CMD] && writable) begin
            st_d.cmd_v = 1'b1;
            st_d.cmd_b = host_wdata[TB-1:0];
        end
        if (wr_sel[ADR_ALT]) begin
            st_d.ctl_v = 1'b1;
            st_d.ctl_b = host_wdata[TB-1:0];
        end
        if (wr_sel[ADR_DATA]) begin
            st_d.pio_wr = 1'b1;
            st_d.pio_wd = host_wdata;
        end

        if (rd_sel[ADR_DATA]) begin
            st_d.rdata  = data_rdata;
            st_d.pio_rd = 1'b1;
        end
        if (rd_sel[ADR_FEAT]) st_d.rdata = DW'(dev_error);
        for (int i = ADR_CNT; i <= ADR_DEV; i++) begin
            if (rd_sel[i]) st_d.rdata = DW'(st_q.tf[i-ADR_FEAT]);
        end
        if (rd_sel[ADR_CMD] || rd_sel[ADR_ALT]) st_d.rdata = DW'(dev_status);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rdata = st_q.rdata;
    assign tf_feature = st_q.tf[0];
    assign tf_count   = st_q.tf[1];
    assign tf_lba     = {st_q.tf[4], st_q.tf[3], st_q.tf[2]};
    assign tf_device  = st_q.tf[5];
    assign cmd_valid  = st_q.cmd_v;
    assign cmd_byte   = st_q.cmd_b;
    assign ctrl_valid = st_q.ctl_v;
    assign ctrl_byte  = st_q.ctl_b;
    assign pio_wr     = st_q.pio_wr;
    assign pio_rd     = st_q.pio_rd;
    assign pio_wdata  = st_q.pio_wd;

    assert_cmd_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == AW'(ADR_CMD) && (dev_status[BSY_BIT] || dev_status[DRQ_BIT]))
        |=> !cmd_valid);
    assert_hold_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_status[BSY_BIT] || dev_status[DRQ_BIT])
        |=> ($stable(tf_count) && $stable(tf_lba) && $stable(tf_device) && $stable(tf_feature)));
    assert_alt_keeps_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_addr == AW'(ADR_ALT) && irq) |=> irq);
    assert_status_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_addr == AW'(ADR_CMD) && !dev_irq_pulse) |=> !irq);
    assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, ctrl_valid, pio_rd, pio_wr}));
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_addr >= AW'(NUM_MAP)) |=> host_rdata == '0);
endmodule

// File: tb/ata_taskfile_regs_tb.sv
module ata_taskfile_regs_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  host_addr = 0;
    logic        host_wr = 0, host_rd = 0;
    logic [15:0] host_wdata = 0, host_rdata;
    logic [7:0]  dev_status = 0, dev_error = 0;
    logic        dev_irq_pulse = 0;
    logic [15:0] data_rdata = 0;
    logic        irq, cmd_valid, ctrl_valid, pio_wr, pio_rd;
    logic [7:0]  tf_feature, tf_count, tf_device, cmd_byte, ctrl_byte;
    logic [23:0] tf_lba;
    logic [15:0] pio_wdata;

    int checks = 0, failures = 0;
    bit done = 0;

    // bench model
    logic [7:0]  m_tf [6];
    logic        m_irq;
    logic [15:0] m_rdata;
    logic        m_cmd_v, m_ctl_v, m_pwr, m_prd;
    logic [7:0]  m_cmd_b, m_ctl_b;
    logic [15:0] m_pwd;

    always #10 clk = ~clk;

    ata_taskfile_regs u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dev_status(dev_status), .dev_error(dev_error), .dev_irq_pulse(dev_irq_pulse),
        .data_rdata(data_rdata), .irq(irq), .tf_feature(tf_feature),
        .tf_count(tf_count), .tf_lba(tf_lba), .tf_device(tf_device),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .ctrl_valid(ctrl_valid),
        .ctrl_byte(ctrl_byte), .pio_wr(pio_wr), .pio_rd(pio_rd), .pio_wdata(pio_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_writable(input logic [7:0] s);
        return !s[7] && !s[3];
    endfunction

    // advance the model by one access (R2..R12)
    task automatic model_step(input bit wr, input bit rd, input int a,
                              input logic [15:0] wd, input bit pulse);
        bit w = is_writable(dev_status);
        bit clr;
        m_rdata = 0; m_cmd_v = 0; m_ctl_v = 0; m_pwr = 0; m_prd = 0;
        clr = (rd && a == 7) || (wr && a == 7 && w);
        if (wr) begin
            if (a >= 1 && a <= 6 && w) m_tf[a-1] = wd[7:0];
            if (a == 7 && w) begin m_cmd_v = 1; m_cmd_b = wd[7:0]; end
            if (a == 8) begin m_ctl_v = 1; m_ctl_b = wd[7:0]; end
            if (a == 0) begin m_pwr = 1; m_pwd = wd; end
        end
        if (rd) begin
            case (a)
                0: begin m_rdata = data_rdata; m_prd = 1; end
                1: m_rdata = {8'h0, dev_error};
                2, 3, 4, 5, 6: m_rdata = {8'h0, m_tf[a-1]};
                7, 8: m_rdata = {8'h0, dev_status};
                default: m_rdata = 0;
            endcase
        end
        if (clr) m_irq = 0;
        if (pulse) m_irq = 1;
    endtask

    task automatic compare_all(input string ctx);
        chk({ctx, " R12 rdata"}, 32'(host_rdata), 32'(m_rdata));
        chk({ctx, " R10 irq"}, 32'(irq), 32'(m_irq));
        chk({ctx, " R2 tf"}, {tf_feature, tf_count, tf_device, 8'h0},
            {m_tf[0], m_tf[1], m_tf[5], 8'h0});
        chk({ctx, " R2 lba"}, 32'(tf_lba), 32'({m_tf[4], m_tf[3], m_tf[2]}));
        chk({ctx, " R4 cmd"}, {23'h0, cmd_valid, cmd_valid ? cmd_byte : 8'h0},
            {23'h0, m_cmd_v, m_cmd_v ? m_cmd_b : 8'h0});
        chk({ctx, " R7 ctrl"}, {23'h0, ctrl_valid, ctrl_valid ? ctrl_byte : 8'h0},
            {23'h0, m_ctl_v, m_ctl_v ? m_ctl_b : 8'h0});
        chk({ctx, " R9 pio"}, {pio_rd, pio_wr, pio_wr ? pio_wdata : 16'h0},
            {m_prd, m_pwr, m_pwr ? m_pwd : 16'h0});
    endtask

    // one access: drive at falling edge, check at the next falling edge
    task automatic access(input string ctx, input bit wr, input bit rd, input int a,
                          input logic [15:0] wd, input logic [7:0] st, input bit pulse);
        host_wr = wr; host_rd = rd; host_addr = 4'(a); host_wdata = wd;
        dev_status = st; dev_irq_pulse = pulse;
        model_step(wr, rd, a, wd, pulse);
        @(negedge clk);
        host_wr = 0; host_rd = 0; dev_irq_pulse = 0;
        compare_all(ctx);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 6; i++) m_tf[i] = 0;
        m_irq = 0; m_rdata = 0; m_cmd_v = 0; m_ctl_v = 0; m_pwr = 0; m_prd = 0;
        m_cmd_b = 0; m_ctl_b = 0; m_pwd = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rdata", 32'(host_rdata), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 strobes", {cmd_valid, ctrl_valid, pio_rd, pio_wr}, 0);
        chk("R1 tf", {tf_feature, tf_count, tf_device}, 0);
        rst_n = 1;
        @(negedge clk);
        dev_error = 8'h5A; data_rdata = 16'hBEEF;

        // directed corner cases
        access("R2 write count", 1, 0, 2, 16'hFF37, 8'h40, 0);
        access("R12 read count", 0, 1, 2, 0, 8'h40, 0);
        access("R3 busy blocks lba", 1, 0, 3, 16'h0011, 8'h80, 0);
        access("R3 drq blocks dev", 1, 0, 6, 16'h00E0, 8'h08, 0);
        access("R8 feature read", 0, 1, 1, 0, 8'h50, 0);
        access("R10 set irq", 0, 0, 0, 0, 8'h50, 1);
        access("R6 alt read keeps irq", 0, 1, 8, 0, 8'h51, 0);
        access("R4 cmd blocked busy", 1, 0, 7, 16'h00EC, 8'h88, 0);
        access("R4 cmd accepted", 1, 0, 7, 16'h00EC, 8'h50, 0);
        access("R10 set", 0, 0, 0, 0, 8'h50, 1);
        access("R10 set beats clear", 0, 1, 7, 0, 8'h50, 1);
        access("R5 status read clears", 0, 1, 7, 0, 8'h50, 0);
        access("R7 devctl while busy", 1, 0, 8, 16'h0004, 8'h80, 0);
        access("R9 pio write", 1, 0, 0, 16'hA5C3, 8'h58, 0);
        access("R9 pio read", 0, 1, 0, 0, 8'h58, 0);
        access("R11 unmapped write", 1, 0, 12, 16'h1234, 8'h40, 0);
        access("R11 unmapped read", 0, 1, 9, 0, 8'h40, 0);

        // constrained random
        for (int n = 0; n < 600; n++) begin
            int kind = $urandom_range(0, 2);
            int a = $urandom_range(0, 10);
            logic [7:0] st = 8'($urandom);
            if ($urandom_range(0, 1) == 1) st = st & 8'h77;   // writable half the time
            dev_error = 8'($urandom);
            data_rdata = 16'($urandom);
            access("rand", kind == 0, kind == 1, a, 16'($urandom), st,
                   $urandom_range(0, 7) == 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule